// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block derives the oversampling strobe for a serial receiver and transmitter from a fast system clock. It does not use an integer counter divider. Instead it keeps a phase accumulator that gains `increment + 1` on every clock. When the accumulated phase reaches the programmed `modulus`, the block wraps it and emits a one-clock oversample tick. Over a long run the tick rate is the clock frequency times `(increment + 1) / modulus`. With a decimal modulus near ten thousand, ratios that are not whole numbers come out accurately. For example, with a 12 MHz clock and a modulus of 10000, an increment of 1535 gives the 16x strobe for 115200 baud.

A second output, the bit tick, marks one out of every 16 oversample ticks. When the clock-to-baud ratio is too small for 16 samples per bit, the mode input selects one out of every 8 instead. Changing the modulus, the increment or the oversampling mode restarts both the phase and the bit count from zero. Dropping the enable does the same. This keeps the two tick streams aligned to the moment the new setting took effect.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, both `os_tick` and `bit_tick` are 0.
- R2: After m accumulating clocks following a restart, the number of `os_tick` pulses seen equals floor(m·(increment+1)/modulus). Each pulse lasts one clock, and `os_tick` is 1 in clock m exactly when this count rose at m.
- R3: If increment+1 is at least modulus, including modulus = 0, the block saturates and `os_tick` is 1 on every accumulating clock.
- R4: With `ovs8_mode` = 0 (16x, the default encoding), `bit_tick` is a one-clock pulse in the clock after every 16th `os_tick` counted from the restart.
- R5: With `ovs8_mode` = 1 (8x), `bit_tick` is a one-clock pulse in the clock after every 8th `os_tick` counted from the restart.
- R6: While `enable` is 0, both outputs are 0 and all internal phase and counting state is cleared. The first clock with `enable` = 1 is accumulating clock 1.
- R7: A clock edge at which `modulus`, `increment` or `ovs8_mode` differs from its value at the previous edge produces no tick on either output. That edge clears the phase and the bit count, and the next edge is accumulating clock 1.
- R8: The accumulator and the compare are 14 bits wide, so any modulus up to 16383 gives the rate of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low clears and holds the generator |
| modulus | input | 14 | Phase wrap value |
| increment | input | 14 | Phase step minus one |
| ovs8_mode | input | 1 | 0 = 16 oversample ticks per bit, 1 = 8 per bit |
| os_tick | output | 1 | One-clock oversample strobe |
| bit_tick | output | 1 | One-clock strobe per bit period |

## Verification
A wrong phase value shows at the ports as an oversample tick that comes one clock early or late. This is visible within one tick period, at most modulus clocks. The bench therefore compares every clock against the floor formula instead of counting only averages. A corrupted bit counter, or an error in the 8x/16x limit, moves `bit_tick` away from the 8th or 16th oversample tick. This shows within one bit period. A missed restart on a setting change or on `enable` leaves a leftover phase, which shifts the first tick after the restart, so each window is checked from its first clock.

// File: rtl/baud_pkg.sv
package baud_pkg;

   typedef enum logic {
      OVS_X16 = 1'b0,
      OVS_X8  = 1'b1
   } ovs_mode_e;

   localparam int unsigned OVS_HI_RATIO = 16;
   localparam int unsigned OVS_LO_RATIO = 8;

endpackage

// File: rtl/baud_cfg_watch.sv
// Keeps the setting seen at the previous edge and requests a restart whenever
// the generator is disabled or any part of the setting differs.
module baud_cfg_watch #(
   parameter int unsigned ACC_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic [ACC_W-1:0] modulus_i,
   input  logic [ACC_W-1:0] increment_i,
   input  baud_pkg::ovs_mode_e mode_i,
   output logic             restart_o
);
   localparam int unsigned CFG_W = 2*ACC_W + 1;

   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;

   assign cfg_now = {modulus_i, increment_i, mode_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         cfg_q <= cfg_now;
      end
   end

   assign restart_o = !enable_i || (cfg_now != cfg_q);

   // R7: a setting that differs from the last edge must be flagged
   p_change_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && !restart_o) |-> (cfg_now == cfg_q));

endmodule

// File: rtl/baud_phase_accum.sv
// Modulus/increment phase accumulator producing the oversample strobe.
module baud_phase_accum #(
   parameter int unsigned ACC_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic [ACC_W-1:0] modulus_i,
   input  logic [ACC_W-1:0] increment_i,
   output logic             os_tick_o
);
   localparam int unsigned SUM_W = ACC_W + 1;

   logic [ACC_W-1:0] phase_q;
   logic [SUM_W-1:0] step;
   logic [SUM_W-1:0] mod_ext;
   logic [SUM_W-1:0] sum;
   logic             saturate;
   logic             wrap;
   logic [ACC_W-1:0] phase_d;

   assign step     = {1'b0, increment_i} + SUM_W'(1);
   assign mod_ext  = {1'b0, modulus_i};
   assign saturate = (step >= mod_ext);
   assign sum      = {1'b0, phase_q} + step;
   assign wrap     = (sum >= mod_ext);

   always_comb begin
      if (saturate) begin
         phase_d = '0;
      end else if (wrap) begin
         phase_d = ACC_W'(sum - mod_ext);
      end else begin
         phase_d = ACC_W'(sum);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= '0;
         os_tick_o <= 1'b0;
      end else if (restart_i) begin
         phase_q   <= '0;
         os_tick_o <= 1'b0;
      end else begin
         phase_q   <= phase_d;
         os_tick_o <= saturate || wrap;
      end
   end

   // R2: once a setting has settled the phase stays below the wrap value
   p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !restart_i |-> ((phase_q < modulus_i) || (phase_q == '0)));

   // R3: an oversized step strobes on every clock
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_i && saturate) |=> os_tick_o);

   // R7: a restart leaves zero phase and no strobe
   p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (phase_q == '0) && !os_tick_o);

endmodule

// File: rtl/baud_bit_div.sv
// Counts oversample strobes and emits one bit strobe per 16 (or 8) of them.
module baud_bit_div #(
   parameter bit ALLOW_X8 = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart_i,
   input  baud_pkg::ovs_mode_e mode_i,
   input  logic                os_tick_i,
   output logic                bit_tick_o
);
   localparam int unsigned CNT_W = $clog2(baud_pkg::OVS_HI_RATIO);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;
   logic             at_last;

   generate
      if (ALLOW_X8) begin : g_two_ratio
         assign last_val = (mode_i == baud_pkg::OVS_X8)
                         ? CNT_W'(baud_pkg::OVS_LO_RATIO - 1)
                         : CNT_W'(baud_pkg::OVS_HI_RATIO - 1);
      end else begin : g_one_ratio
         assign last_val = CNT_W'(baud_pkg::OVS_HI_RATIO - 1);
      end
   endgenerate

   assign at_last = (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         bit_tick_o <= 1'b0;
      end else if (restart_i) begin
         cnt_q      <= '0;
         bit_tick_o <= 1'b0;
      end else if (os_tick_i) begin
         cnt_q      <= at_last ? '0 : cnt_q + CNT_W'(1);
         bit_tick_o <= at_last;
      end else begin
         bit_tick_o <= 1'b0;
      end
   end

   // R4: a bit strobe always follows an oversample strobe by one clock
   p_bit_after_os_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick_o |-> $past(os_tick_i));

   // R5: the count never passes the limit for the chosen ratio
   p_cnt_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !restart_i |-> (cnt_q <= last_val));

   // R7: a restart empties the counter
   p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0) && !bit_tick_o);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
   parameter int unsigned ACC_W    = 14,
   parameter bit          ALLOW_X8 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [ACC_W-1:0] modulus,
   input  logic [ACC_W-1:0] increment,
   input  logic             ovs8_mode,
   output logic             os_tick,
   output logic             bit_tick
);
   localparam int unsigned MIN_ACC_W = 14;

   generate
      if (ACC_W < MIN_ACC_W) begin : g_bad_width
         $error("baud_tick_gen: ACC_W must be at least 14 (R8)");
      end
      if (ACC_W > 30) begin : g_too_wide
         $error("baud_tick_gen: ACC_W above 30 is not supported");
      end
   endgenerate

   baud_pkg::ovs_mode_e mode;
   logic                restart;

   assign mode = baud_pkg::ovs_mode_e'(ovs8_mode);

   baud_cfg_watch #(.ACC_W(ACC_W)) u_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_i    (enable),
      .modulus_i   (modulus),
      .increment_i (increment),
      .mode_i      (mode),
      .restart_o   (restart)
   );

   baud_phase_accum #(.ACC_W(ACC_W)) u_accum (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart_i   (restart),
      .modulus_i   (modulus),
      .increment_i (increment),
      .os_tick_o   (os_tick)
   );

   baud_bit_div #(.ALLOW_X8(ALLOW_X8)) u_bitdiv (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (restart),
      .mode_i     (mode),
      .os_tick_i  (os_tick),
      .bit_tick_o (bit_tick)
   );

   // R6: a disabled generator is silent on the next clock
   p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!os_tick && !bit_tick));

   // R1: no strobe may leave reset already set
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!os_tick && !bit_tick));

endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
   localparam int ACC_W = 14;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic [ACC_W-1:0] modulus = '0;
   logic [ACC_W-1:0] increment = '0;
   logic             ovs8_mode = 1'b0;
   logic             os_tick;
   logic             bit_tick;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   baud_tick_gen #(.ACC_W(ACC_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .modulus   (modulus),
      .increment (increment),
      .ovs8_mode (ovs8_mode),
      .os_tick   (os_tick),
      .bit_tick  (bit_tick)
   );

   // total oversample ticks after m accumulating clocks
   function automatic longint ticks_after(longint m, longint md, longint inc);
      longint st;
      st = inc + 1;
      if (m <= 0) return 0;
      if (st >= md) return m;
      return (m * st) / md;
   endfunction

   function automatic bit exp_os(longint m, longint md, longint inc);
      if (m < 1) return 1'b0;
      return ticks_after(m, md, inc) != ticks_after(m - 1, md, inc);
   endfunction

   function automatic bit exp_bit(longint m, longint md, longint inc, bit x8);
      longint d;
      d = x8 ? 8 : 16;
      if (m < 2) return 1'b0;
      return exp_os(m - 1, md, inc) && ((ticks_after(m - 1, md, inc) % d) == 0);
   endfunction

   task automatic check_bit(string req, bit act, bit exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // assumes accumulating clock 0 has just passed; checks clocks 1..len
   task automatic run_window(int len, string req_os, string req_bit);
      longint md;
      longint inc;
      bit     x8;
      md  = modulus;
      inc = increment;
      x8  = ovs8_mode;
      for (int m = 1; m <= len; m++) begin
         @(negedge clk);
         check_bit(req_os, os_tick, exp_os(m, md, inc), "os_tick");
         check_bit(req_bit, bit_tick, exp_bit(m, md, inc, x8), "bit_tick");
      end
   endtask

   // restart through enable low, then check a window
   task automatic start_disabled(int md, int inc, bit x8, int len, string req_os, string req_bit);
      enable    = 1'b0;
      modulus   = ACC_W'(md);
      increment = ACC_W'(inc);
      ovs8_mode = x8;
      @(negedge clk);
      check_bit("R6", os_tick, 1'b0, "os_tick while disabled");
      check_bit("R6", bit_tick, 1'b0, "bit_tick while disabled");
      enable = 1'b1;
      run_window(len, req_os, req_bit);
   endtask

   // restart through a setting change with enable held high
   task automatic start_change(int md, int inc, bit x8, int len, string req_os, string req_bit);
      modulus   = ACC_W'(md);
      increment = ACC_W'(inc);
      ovs8_mode = x8;
      @(negedge clk);
      check_bit("R7", os_tick, 1'b0, "os_tick at change edge");
      check_bit("R7", bit_tick, 1'b0, "bit_tick at change edge");
      run_window(len, req_os, req_bit);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      check_bit("R1", os_tick, 1'b0, "os_tick in reset");
      check_bit("R1", bit_tick, 1'b0, "bit_tick in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1", os_tick, 1'b0, "os_tick after reset");
      check_bit("R1", bit_tick, 1'b0, "bit_tick after reset");

      // R2/R4: a ratio near 115200 baud at 12 MHz, 16x
      start_disabled(10000, 1535, 1'b0, 1500, "R2", "R4");
      // R5: 921600-baud-like ratio, 8x
      start_disabled(10000, 6143, 1'b1, 800, "R2", "R5");
      // R4: small increment, 16x
      start_disabled(10000, 127, 1'b0, 3000, "R2", "R4");
      // R3: step exactly equal to modulus, and larger than modulus
      start_disabled(16383, 16382, 1'b0, 100, "R3", "R4");
      start_change(100, 500, 1'b1, 60, "R3", "R5");
      // R3: modulus zero saturates
      start_change(0, 0, 1'b0, 40, "R3", "R4");
      // R8: full 14-bit modulus
      start_disabled(16383, 8190, 1'b1, 700, "R8", "R5");

      // R7: mid-run changes of each field restart the phase
      start_disabled(10000, 3071, 1'b0, 137, "R2", "R4");
      start_change(10000, 3070, 1'b0, 411, "R7", "R7");
      start_change(9999, 3070, 1'b0, 411, "R7", "R7");
      start_change(9999, 3070, 1'b1, 411, "R7", "R7");
      // R6: drop enable mid-run and resume with the same setting
      start_disabled(9999, 3070, 1'b1, 300, "R6", "R6");

      // random settings, alternating restart paths
      for (int k = 0; k < 24; k++) begin
         int md;
         int inc;
         bit x8;
         md  = (k % 3 == 0) ? 10000 : int'($urandom_range(16383, 1));
         inc = (k % 5 == 4) ? int'($urandom_range(16383, 0))
                            : int'($urandom_range(md - 1, md / 64));
         x8  = 1'($urandom_range(1, 0));
         if (k % 2 == 0)
            start_disabled(md, inc, x8, 1200, "R2", x8 ? "R5" : "R4");
         else
            start_change(md, inc, x8, 1200, "R7", x8 ? "R5" : "R4");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule